// File: doc/BRIEF.md
# Register-Access Mailbox Request Sequencer

This block turns one register-access request into the full exchange with a word-wide mailbox. A request names an operation (write, read or masked update), an item count, up to five 16-bit register addresses and up to five data bytes. The sequencer latches the request and builds the byte payload for the chosen operation. It stores the payload into the mailbox write buffer as 32-bit words and then writes the command word.

After the command word, it polls the mailbox status word until busy clears. The gap between polls is a set number of clock cycles, and the number of polls is bounded. When a read succeeds, it fetches the result bytes from the mailbox read buffer. It finishes with a one-cycle done pulse, a two-bit result code and the result bytes.

The mailbox is a simple register port. A write is one cycle of `mb_wr`. A read is one cycle of `mb_rd`, and the mailbox presents its data on `mb_rdata` in the following cycle. The mailbox decodes these offsets: command word 0x00, status 0x04, write buffer from 0x80, read buffer from 0x90. Status bit 0 means busy and status bit 1 means error. Result codes are 0 ok, 1 device error, 2 timeout and 3 invalid request.

Top module: `ipc_regseq`

## Requirements
- R1: The command word is written to offset 0x00 only after all write-buffer words. Its bits 7:0 are 0xFF and bits 15:12 carry the operation (0 write, 1 read, 2 masked update). Bits 23:16 carry the payload size in bytes. Bits 11:8 and 31:24 are zero, so the completion-interrupt bit 8 is never set.
- R2: Address n of the request occupies payload bytes 2n (low half) and 2n+1 (high half). Payload byte 4k+j goes to bits 8j+7:8j of the word written at offset 0x80+4k. Words are written for ascending k, exactly ceil(size/4) of them, and unused bytes of the last word are zero.
- R3: For a write (op 0), data byte n sits at payload byte 2*count+n, and the size is 3*count.
- R4: For a read (op 1), the size is 2*count. On success the block reads ceil(count/4) words from offset 0x90+4k. Result byte n (bits 8n+7:8n of `rsp_rdata`) equals read-buffer byte n for n < count, and the result bytes at or above count are zero.
- R5: For a masked update (op 2), the payload is the address pair, then the new value (data byte 0) at byte 2, then the mask (data byte 1) at byte 3, with size 4.
- R6: The block reads status at offset 0x04 while busy, leaving INTERVAL_CYC idle cycles between a status read's data cycle and the next read. It reads at most MAX_POLLS times. If busy is still set on the last read, it reports code 2.
- R7: If busy is clear and the error bit is set, the block reports code 1 and does no read-buffer access. If busy is clear and error is clear, it reports code 0.
- R8: A request is invalid if the count is 0, the count exceeds MAX_ITEMS, the op is 3, or a masked update has a count other than 1. An invalid request gives done with code 3 in the cycle after acceptance, with no mailbox access.
- R9: `req_ready` is high only when idle, and a request is taken when `req_valid` and `req_ready` are both high. `rsp_done` lasts one cycle. `rsp_err` and `rsp_rdata` hold until the next acceptance. After reset, ready is 1, and done, code and result bytes are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request will be taken |
| req_op | input | 2 | 0 write, 1 read, 2 masked update |
| req_count | input | 3 | Number of items |
| req_addr | input | 80 | Register addresses, item n at bits 16n+15:16n |
| req_data | input | 40 | Data bytes, byte n at bits 8n+7:8n |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_err | output | 2 | Result code |
| rsp_rdata | output | 40 | Result bytes of a read |
| mb_wr | output | 1 | Mailbox write strobe |
| mb_rd | output | 1 | Mailbox read strobe |
| mb_addr | output | 8 | Mailbox byte offset |
| mb_wdata | output | 32 | Mailbox write data |
| mb_rdata | input | 32 | Mailbox read data, valid the cycle after `mb_rd` |

## Verification
The assertions assume the mailbox holds `mb_rdata` valid in the cycle after a read, as the interface defines. They also assume requesters raise `req_valid` only with fully driven op and count fields. The bench's mailbox model returns registered data one cycle after each strobe, and it changes its busy and error settings only between requests. Busy is counted in status reads, not in time, so the interval, boundary and timeout cases are independent of the gap length. Every request is issued while the block is idle with defined field values.

// File: rtl/ipc_regseq_pkg.sv
package ipc_regseq_pkg;

    typedef enum logic [1:0] {
        OP_WRITE  = 2'd0,
        OP_READ   = 2'd1,
        OP_UPDATE = 2'd2,
        OP_NONE   = 2'd3
    } req_op_e;

    typedef enum logic [1:0] {
        RES_OK      = 2'd0,
        RES_DEVICE  = 2'd1,
        RES_TIMEOUT = 2'd2,
        RES_INVALID = 2'd3
    } res_code_e;

    typedef enum logic [3:0] {
        SQ_IDLE,
        SQ_WBUF,
        SQ_CMD,
        SQ_PREAD,
        SQ_PCHK,
        SQ_GAP,
        SQ_RREQ,
        SQ_RCAP,
        SQ_DONE
    } seq_state_e;

    localparam logic [7:0] CMD_CODE  = 8'hFF;
    localparam logic [7:0] OFS_CMD   = 8'h00;
    localparam logic [7:0] OFS_STAT  = 8'h04;
    localparam logic [7:0] OFS_WBUF  = 8'h80;
    localparam logic [7:0] OFS_RBUF  = 8'h90;
    localparam int         STAT_BUSY = 0;
    localparam int         STAT_ERR  = 1;

endpackage

// File: rtl/ipc_payload_pack.sv
module ipc_payload_pack
    import ipc_regseq_pkg::*;
#(
    parameter int MAX_ITEMS = 5,
    localparam int CNT_W     = $clog2(MAX_ITEMS + 1),
    localparam int PAY_WORDS = (3 * MAX_ITEMS + 3) / 4,
    localparam int PAY_BYTES = PAY_WORDS * 4,
    localparam int WIDX_W    = $clog2(PAY_WORDS + 1)
) (
    input  logic [1:0]              op,
    input  logic [CNT_W-1:0]        cnt,
    input  logic [MAX_ITEMS*16-1:0] addr,
    input  logic [MAX_ITEMS*8-1:0]  data,
    output logic [PAY_BYTES*8-1:0]  pay,
    output logic [7:0]              size,
    output logic [WIDX_W-1:0]       nwords,
    output logic                    bad
);

    logic [7:0] bytes [PAY_BYTES];
    int         sz;

    always_comb begin
        for (int b = 0; b < PAY_BYTES; b++) begin
            bytes[b] = 8'h00;
        end
        sz = 0;
        // address pairs, low byte first
        for (int i = 0; i < MAX_ITEMS; i++) begin
            if (i < int'(cnt)) begin
                bytes[2*i]     = addr[i*16 +: 8];
                bytes[2*i + 1] = addr[i*16 + 8 +: 8];
            end
        end
        case (req_op_e'(op))
            OP_WRITE: begin
                for (int i = 0; i < MAX_ITEMS; i++) begin
                    if ((i < int'(cnt)) && ((2*int'(cnt) + i) < PAY_BYTES)) begin
                        bytes[2*int'(cnt) + i] = data[i*8 +: 8];
                    end
                end
                sz = 3 * int'(cnt);
            end
            OP_READ: begin
                sz = 2 * int'(cnt);
            end
            OP_UPDATE: begin
                bytes[2] = data[7:0];
                bytes[3] = data[15:8];
                sz = 4;
            end
            default: begin
                sz = 0;
            end
        endcase
    end

    generate
        for (genvar g = 0; g < PAY_BYTES; g++) begin : g_flat
            assign pay[g*8 +: 8] = bytes[g];
        end
    endgenerate

    assign size   = 8'(sz);
    assign nwords = WIDX_W'((sz + 3) / 4);
    assign bad    = (cnt == '0)
                 || (int'(cnt) > MAX_ITEMS)
                 || (op == OP_NONE)
                 || ((op == OP_UPDATE) && (int'(cnt) != 1));

endmodule

// File: rtl/ipc_gap_timer.sv
module ipc_gap_timer #(
    parameter int INTERVAL_CYC = 100,
    localparam int TW = $clog2(INTERVAL_CYC + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic expired
);

    logic [TW-1:0] cnt_d, cnt_q;

    always_comb begin
        if (start) begin
            cnt_d = TW'(INTERVAL_CYC - 1);
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end else begin
            cnt_d = cnt_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/ipc_regseq.sv
module ipc_regseq
    import ipc_regseq_pkg::*;
#(
    parameter int MAX_ITEMS    = 5,
    parameter int MAX_POLLS    = 100000,
    parameter int INTERVAL_CYC = 100,
    localparam int CNT_W     = $clog2(MAX_ITEMS + 1),
    localparam int PAY_WORDS = (3 * MAX_ITEMS + 3) / 4,
    localparam int PAY_BITS  = PAY_WORDS * 32,
    localparam int WIDX_W    = $clog2(PAY_WORDS + 1),
    localparam int POLL_W    = $clog2(MAX_POLLS + 1),
    localparam int RD_BITS   = MAX_ITEMS * 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    output logic                    req_ready,
    input  logic [1:0]              req_op,
    input  logic [CNT_W-1:0]        req_count,
    input  logic [MAX_ITEMS*16-1:0] req_addr,
    input  logic [MAX_ITEMS*8-1:0]  req_data,
    output logic                    rsp_done,
    output logic [1:0]              rsp_err,
    output logic [RD_BITS-1:0]      rsp_rdata,
    output logic                    mb_wr,
    output logic                    mb_rd,
    output logic [7:0]              mb_addr,
    output logic [31:0]             mb_wdata,
    input  logic [31:0]             mb_rdata
);

    typedef struct packed {
        seq_state_e          st;
        logic [WIDX_W-1:0]   widx;
        logic [WIDX_W-1:0]   nwords;
        logic [POLL_W-1:0]   polls;
        logic [PAY_BITS-1:0] pay;
        logic [7:0]          size;
        logic [1:0]          op;
        logic [CNT_W-1:0]    cnt;
        logic [RD_BITS-1:0]  rdata;
        logic [1:0]          err;
    } seq_t;

    seq_t seq_d, seq_q;

    logic [PAY_BITS-1:0] pk_pay;
    logic [7:0]          pk_size;
    logic [WIDX_W-1:0]   pk_nwords;
    logic                pk_bad;
    logic                tmr_start;
    logic                tmr_expired;
    logic [WIDX_W-1:0]   rwords;

    ipc_payload_pack #(.MAX_ITEMS(MAX_ITEMS)) u_pack (
        .op     (req_op),
        .cnt    (req_count),
        .addr   (req_addr),
        .data   (req_data),
        .pay    (pk_pay),
        .size   (pk_size),
        .nwords (pk_nwords),
        .bad    (pk_bad)
    );

    ipc_gap_timer #(.INTERVAL_CYC(INTERVAL_CYC)) u_gap (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (tmr_start),
        .expired (tmr_expired)
    );

    assign rwords = WIDX_W'((int'(seq_q.cnt) + 3) / 4);

    always_comb begin
        seq_d     = seq_q;
        tmr_start = 1'b0;
        mb_wr     = 1'b0;
        mb_rd     = 1'b0;
        mb_addr   = 8'h00;
        mb_wdata  = 32'h0;
        case (seq_q.st)
            SQ_IDLE: begin
                if (req_valid) begin
                    seq_d.rdata  = '0;
                    seq_d.err    = RES_OK;
                    seq_d.op     = req_op;
                    seq_d.cnt    = req_count;
                    seq_d.pay    = pk_pay;
                    seq_d.size   = pk_size;
                    seq_d.nwords = pk_nwords;
                    seq_d.widx   = '0;
                    seq_d.polls  = '0;
                    if (pk_bad) begin
                        seq_d.err = RES_INVALID;
                        seq_d.st  = SQ_DONE;
                    end else begin
                        seq_d.st  = SQ_WBUF;
                    end
                end
            end
            SQ_WBUF: begin
                mb_wr    = 1'b1;
                mb_addr  = OFS_WBUF + 8'(int'(seq_q.widx) * 4);
                mb_wdata = seq_q.pay[int'(seq_q.widx)*32 +: 32];
                if (seq_q.widx == seq_q.nwords - 1'b1) begin
                    seq_d.widx = '0;
                    seq_d.st   = SQ_CMD;
                end else begin
                    seq_d.widx = seq_q.widx + 1'b1;
                end
            end
            SQ_CMD: begin
                mb_wr    = 1'b1;
                mb_addr  = OFS_CMD;
                mb_wdata = {8'h00, seq_q.size, 2'b00, seq_q.op, 4'h0, CMD_CODE};
                seq_d.st = SQ_PREAD;
            end
            SQ_PREAD: begin
                mb_rd    = 1'b1;
                mb_addr  = OFS_STAT;
                seq_d.st = SQ_PCHK;
            end
            SQ_PCHK: begin
                if (mb_rdata[STAT_BUSY]) begin
                    if (seq_q.polls == POLL_W'(MAX_POLLS - 1)) begin
                        seq_d.err = RES_TIMEOUT;
                        seq_d.st  = SQ_DONE;
                    end else begin
                        seq_d.polls = seq_q.polls + 1'b1;
                        tmr_start   = 1'b1;
                        seq_d.st    = SQ_GAP;
                    end
                end else if (mb_rdata[STAT_ERR]) begin
                    seq_d.err = RES_DEVICE;
                    seq_d.st  = SQ_DONE;
                end else if (seq_q.op == OP_READ) begin
                    seq_d.widx = '0;
                    seq_d.st   = SQ_RREQ;
                end else begin
                    seq_d.st   = SQ_DONE;
                end
            end
            SQ_GAP: begin
                if (tmr_expired) begin
                    seq_d.st = SQ_PREAD;
                end
            end
            SQ_RREQ: begin
                mb_rd    = 1'b1;
                mb_addr  = OFS_RBUF + 8'(int'(seq_q.widx) * 4);
                seq_d.st = SQ_RCAP;
            end
            SQ_RCAP: begin
                for (int k = 0; k < 4; k++) begin
                    if (((4*int'(seq_q.widx) + k) < MAX_ITEMS)
                        && ((4*int'(seq_q.widx) + k) < int'(seq_q.cnt))) begin
                        seq_d.rdata[(4*int'(seq_q.widx) + k)*8 +: 8] = mb_rdata[k*8 +: 8];
                    end
                end
                if (seq_q.widx == rwords - 1'b1) begin
                    seq_d.st = SQ_DONE;
                end else begin
                    seq_d.widx = seq_q.widx + 1'b1;
                    seq_d.st   = SQ_RREQ;
                end
            end
            SQ_DONE: begin
                seq_d.st = SQ_IDLE;
            end
            default: begin
                seq_d.st = SQ_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q    <= '0;
            seq_q.st <= SQ_IDLE;
        end else begin
            seq_q    <= seq_d;
        end
    end

    assign req_ready = (seq_q.st == SQ_IDLE);
    assign rsp_done  = (seq_q.st == SQ_DONE);
    assign rsp_err   = seq_q.err;
    assign rsp_rdata = seq_q.rdata;

endmodule

// File: rtl/ipc_regseq_chk.sv
module ipc_regseq_chk #(
    parameter int MAX_ITEMS = 5,
    localparam int CNT_W = $clog2(MAX_ITEMS + 1)
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   req_valid,
    input logic                   req_ready,
    input logic [1:0]             req_op,
    input logic [CNT_W-1:0]       req_count,
    input logic                   rsp_done,
    input logic [1:0]             rsp_err,
    input logic [MAX_ITEMS*8-1:0] rsp_rdata,
    input logic                   mb_wr,
    input logic                   mb_rd,
    input logic [7:0]             mb_addr,
    input logic [31:0]            mb_wdata
);

    logic req_invalid;
    assign req_invalid = (req_count == '0) || (int'(req_count) > MAX_ITEMS)
                      || (req_op == 2'd3) || ((req_op == 2'd2) && (req_count != CNT_W'(1)));

    AST_CMD_FIXED_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
        (mb_wr && mb_addr == 8'h00) |-> (mb_wdata[7:0] == 8'hFF && mb_wdata[11:8] == 4'h0 && mb_wdata[31:24] == 8'h00)); // R1

    AST_SIZE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (mb_wr && mb_addr == 8'h00) |-> (mb_wdata[23:16] != 8'h00 && mb_wdata[23:16] <= 8'(3 * MAX_ITEMS))); // R3

    AST_SINGLE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !(mb_wr && mb_rd)); // R2

    AST_INVALID_FAST: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_invalid) |=> (rsp_done && rsp_err == 2'd3 && !mb_wr && !mb_rd)); // R8

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!mb_wr && !mb_rd)); // R9

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done); // R9

    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> ($stable(rsp_err) && $stable(rsp_rdata))); // R9

endmodule

bind ipc_regseq ipc_regseq_chk #(.MAX_ITEMS(MAX_ITEMS)) u_chk (.*);

// File: tb/ipc_regseq_bench.sv
module ipc_regseq_bench;

    localparam int MAXI  = 5;
    localparam int MAXP  = 8;
    localparam int GAPC  = 3;

    typedef struct packed {
        logic [1:0]  op;
        logic [2:0]  cnt;
        logic [79:0] addr;
        logic [39:0] data;
        logic [7:0]  busy;
        logic        err;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 3'd1, 80'h0000_0000_0000_0000_0123, 40'h00_0000_005A, 8'd0, 1'b0},
        '{2'd0, 3'd5, 80'h0105_0104_0103_0102_0101, 40'hE5_D4_C3_B2_A1, 8'd2, 1'b0},
        '{2'd1, 3'd1, 80'h0000_0000_0000_0000_0042, 40'h00_0000_0000, 8'd1, 1'b0},
        '{2'd1, 3'd5, 80'h0214_0213_0212_0211_0210, 40'h00_0000_0000, 8'd0, 1'b0},
        '{2'd2, 3'd1, 80'h0000_0000_0000_0000_00C7, 40'h00_0000_0F3C, 8'd3, 1'b0},
        '{2'd0, 3'd2, 80'h0000_0000_0000_0301_0300, 40'h00_0000_7766, 8'd0, 1'b1},
        '{2'd1, 3'd4, 80'h0000_0403_0402_0401_0400, 40'h00_0000_0000, 8'd1, 1'b1},
        '{2'd0, 3'd1, 80'h0000_0000_0000_0000_0777, 40'h00_0000_0099, 8'd7, 1'b0},
        '{2'd1, 3'd2, 80'h0000_0000_0000_0889_0888, 40'h00_0000_0000, 8'd8, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_op = 2'd0;
    logic [2:0]  req_count = 3'd0;
    logic [79:0] req_addr = '0;
    logic [39:0] req_data = '0;
    logic        rsp_done;
    logic [1:0]  rsp_err;
    logic [39:0] rsp_rdata;
    logic        mb_wr;
    logic        mb_rd;
    logic [7:0]  mb_addr;
    logic [31:0] mb_wdata;
    logic [31:0] mb_rdata;

    int n_chk = 0;
    int n_err = 0;
    bit all_done = 1'b0;

    always #5 clk = ~clk;

    ipc_regseq #(.MAX_ITEMS(MAXI), .MAX_POLLS(MAXP), .INTERVAL_CYC(GAPC)) u_ipc_regseq (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
        .req_count(req_count), .req_addr(req_addr), .req_data(req_data),
        .rsp_done(rsp_done), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
        .mb_wr(mb_wr), .mb_rd(mb_rd), .mb_addr(mb_addr),
        .mb_wdata(mb_wdata), .mb_rdata(mb_rdata)
    );

    // ---------------- mailbox model ----------------
    logic        log_clr = 1'b0;
    int          cfg_busy = 0;
    logic        cfg_err = 1'b0;
    logic [7:0]  rbuf_b [8];
    logic [31:0] m_wbuf [4];
    logic [31:0] m_cmd;
    int          n_wbuf, n_cmd, n_stat, n_rbuf, wbuf_at_cmd, busy_left;
    int          cyc, last_stat, stat_gap;
    logic [31:0] rd_q;

    assign mb_rdata = rd_q;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (log_clr) begin
            for (int i = 0; i < 4; i++) m_wbuf[i] <= 32'h0;
            m_cmd <= 32'h0; n_wbuf <= 0; n_cmd <= 0; n_stat <= 0; n_rbuf <= 0;
            wbuf_at_cmd <= 0; busy_left <= 0; stat_gap <= 0; last_stat <= 0;
        end else if (mb_wr) begin
            if (mb_addr == 8'h00) begin
                m_cmd <= mb_wdata; n_cmd <= n_cmd + 1;
                wbuf_at_cmd <= n_wbuf; busy_left <= cfg_busy;
            end else if (mb_addr >= 8'h80 && mb_addr < 8'h90) begin
                m_wbuf[(mb_addr - 8'h80) >> 2] <= mb_wdata;
                n_wbuf <= n_wbuf + 1;
            end
        end else if (mb_rd) begin
            if (mb_addr == 8'h04) begin
                rd_q <= {30'h0, cfg_err, busy_left != 0};
                if (busy_left != 0) busy_left <= busy_left - 1;
                if (n_stat > 0) stat_gap <= cyc - last_stat;
                last_stat <= cyc;
                n_stat <= n_stat + 1;
            end else if (mb_addr == 8'h90 || mb_addr == 8'h94) begin
                rd_q <= {rbuf_b[(mb_addr - 8'h90) + 3], rbuf_b[(mb_addr - 8'h90) + 2],
                         rbuf_b[(mb_addr - 8'h90) + 1], rbuf_b[(mb_addr - 8'h90)]};
                n_rbuf <= n_rbuf + 1;
            end
        end
    end

    // ---------------- reference ----------------
    function automatic logic [127:0] ref_payload(vec_t v);
        logic [7:0] b [16];
        logic [127:0] r;
        int c = int'(v.cnt);
        for (int i = 0; i < 16; i++) b[i] = 8'h00;
        for (int i = 0; i < c; i++) begin
            b[2*i] = v.addr[i*16 +: 8];
            b[2*i+1] = v.addr[i*16+8 +: 8];
        end
        if (v.op == 2'd0) for (int i = 0; i < c; i++) b[2*c+i] = v.data[i*8 +: 8];
        if (v.op == 2'd2) begin b[2] = v.data[7:0]; b[3] = v.data[15:8]; end
        for (int i = 0; i < 16; i++) r[i*8 +: 8] = b[i];
        return r;
    endfunction

    function automatic int ref_size(vec_t v);
        if (v.op == 2'd0) return 3 * int'(v.cnt);
        if (v.op == 2'd1) return 2 * int'(v.cnt);
        return 4;
    endfunction

    task automatic chk(string rq, string what, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    task automatic issue(vec_t v, int tag, output bit got_done);
        @(negedge clk);
        log_clr  = 1'b1;
        cfg_busy = int'(v.busy);
        cfg_err  = v.err;
        for (int n = 0; n < 8; n++) rbuf_b[n] = 8'(8'h40 + tag*8 + n);
        @(negedge clk);
        log_clr   = 1'b0;
        req_valid = 1'b1;
        req_op    = v.op;
        req_count = v.cnt;
        req_addr  = v.addr;
        req_data  = v.data;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R9", "ready low after accept", 64'(req_ready), 64'd0);
        got_done = rsp_done;
        for (int w = 0; w < 2000 && !got_done; w++) begin
            @(negedge clk);
            got_done = rsp_done;
        end
    endtask

    task automatic run_vec(vec_t v, int tag);
        bit dn;
        int sz, nw, en_stat, en_rbuf;
        logic [1:0] eerr;
        logic [127:0] pay;
        logic [39:0] erd;
        logic [31:0] ecmd;
        issue(v, tag, dn);
        chk("R9", "done seen", 64'(dn), 64'd1);
        sz  = ref_size(v);
        nw  = (sz + 3) / 4;
        pay = ref_payload(v);
        eerr = (int'(v.busy) >= MAXP) ? 2'd2 : (v.err ? 2'd1 : 2'd0);
        en_stat = (int'(v.busy) >= MAXP) ? MAXP : int'(v.busy) + 1;
        en_rbuf = (eerr == 2'd0 && v.op == 2'd1) ? (int'(v.cnt) + 3) / 4 : 0;
        ecmd = {8'h00, 8'(sz), 2'b00, v.op, 4'h0, 8'hFF};
        erd = '0;
        if (eerr == 2'd0 && v.op == 2'd1)
            for (int n = 0; n < int'(v.cnt); n++) erd[n*8 +: 8] = 8'(8'h40 + tag*8 + n);
        chk(eerr == 2'd2 ? "R6" : "R7", "result code", 64'(rsp_err), 64'(eerr));
        chk("R1", "command word", 64'(m_cmd), 64'(ecmd));
        chk("R1", "command after payload", 64'(wbuf_at_cmd), 64'(nw));
        chk("R2", "payload word count", 64'(n_wbuf), 64'(nw));
        for (int k = 0; k < nw; k++)
            chk(v.op == 2'd0 ? "R3" : (v.op == 2'd2 ? "R5" : "R2"), "payload word",
                64'(m_wbuf[k]), 64'(pay[k*32 +: 32]));
        chk("R6", "status reads", 64'(n_stat), 64'(en_stat));
        if (en_stat > 1) chk("R6", "poll spacing", 64'(stat_gap), 64'(GAPC + 2));
        chk(v.err ? "R7" : "R4", "read-buffer reads", 64'(n_rbuf), 64'(en_rbuf));
        chk("R4", "result bytes", 64'(rsp_rdata), 64'(erd));
        repeat (3) @(negedge clk);
        chk("R9", "done single cycle", 64'(rsp_done), 64'd0);
        chk("R9", "code held", 64'(rsp_err), 64'(eerr));
        chk("R9", "result held", 64'(rsp_rdata), 64'(erd));
    endtask

    task automatic run_invalid(logic [1:0] op, logic [2:0] cnt, int tag);
        vec_t v;
        bit dn;
        v = '{op, cnt, 80'h0000_0000_0000_0AB1_0AB0, 40'h00_0000_5544, 8'd0, 1'b0};
        @(negedge clk);
        log_clr = 1'b1;
        @(negedge clk);
        log_clr = 1'b0;
        req_valid = 1'b1; req_op = op; req_count = cnt;
        req_addr = v.addr; req_data = v.data;
        @(negedge clk);
        req_valid = 1'b0;
        dn = rsp_done;
        chk("R8", $sformatf("done next cycle case %0d", tag), 64'(dn), 64'd1);
        chk("R8", $sformatf("invalid code case %0d", tag), 64'(rsp_err), 64'd3);
        @(negedge clk);
        chk("R8", $sformatf("no mailbox access case %0d", tag),
            64'(n_wbuf + n_cmd + n_stat + n_rbuf), 64'd0);
        chk("R9", "ready after invalid", 64'(req_ready), 64'd1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!all_done) begin
            n_err++; n_chk++;
            $display("FAIL R9 watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        cyc = 0;
        rd_q = 32'h0;
        for (int n = 0; n < 8; n++) rbuf_b[n] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state
        chk("R9", "reset ready", 64'(req_ready), 64'd1);
        chk("R9", "reset done", 64'(rsp_done), 64'd0);
        chk("R9", "reset code", 64'(rsp_err), 64'd0);
        chk("R9", "reset result", 64'(rsp_rdata), 64'd0);
        chk("R9", "reset bus idle", 64'({mb_wr, mb_rd}), 64'd0);
        // table walk
        for (int t = 0; t < NV; t++) run_vec(VECS[t], t);
        // invalid requests (R8)
        run_invalid(2'd0, 3'd0, 0);
        run_invalid(2'd1, 3'd6, 1);
        run_invalid(2'd2, 3'd2, 2);
        run_invalid(2'd3, 3'd1, 3);
        // valid request after invalid ones still works
        run_vec(VECS[2], 9);
        all_done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule